// File: doc/BRIEF.md
# Trace Schedule Word Placement Unit

This unit builds the schedule for a statically scheduled replay of a hot code region. It takes the micro-ops that an out-of-order core retired from that region, one per cycle and in retirement order. For each op it picks the wide instruction word the op will issue from. Each physical source is resolved through a mapping table that is indexed by physical register. A source that has no entry yet is a value flowing into the region. It is flagged as such, together with its architectural register, and is treated as available at word 0. Each destination gets the next free register from a small temporary register pool. The table also keeps the word that produced the value and how long that value took to produce.

An op is placed at the latest ready time of its register sources, which is the producer's word plus the producer's measured latency. If that word already holds six ops, the op goes to the next word with a free slot. Each word keeps a dependency prefix: the latest producer word that any op in it depends on. A later executor can then wait on that word instead of padding the schedule with empty words. A pulse on `frame_start` begins a new region and clears all state. If the temporary pool, the per-region op budget or the word space runs out, construction stops and a sticky abort flag is raised.

Top module: `trace_word_placer`

## Requirements
- R1: After reset or a `frame_start` cycle, `abort` is 0, `res_valid` is 0, every physical register is unmapped, every word is empty and both the temporary register allocator and the op count restart at 0. An op presented in the same cycle as `frame_start` is dropped.
- R2: A register source with no mapping is reported with `res_srcN_livein`=1, `res_srcN_vreg`=0 and `res_srcN_arch` equal to its architectural ID. It adds a live-in entry, so later reads of that physical register in the same region are also live-ins and report the architectural ID that was stored first. A live-in constrains placement only to word 0 and never counts as a dependency.
- R3: Each op with a destination gets the next temporary register ID, counting up from 0 in each region, reported on `res_dst_vreg`. A later source that reads that physical register reports the same ID with `res_srcN_livein`=0 and `res_srcN_arch`=0.
- R4: The latency stored for a destination is `retire_cyc - dispatch_cyc`, raised to at least 1 and capped at 15.
- R5: The target word of an op is the maximum of (producer word + producer latency) over its mapped, non-live-in register sources, or 0 if it has none.
- R6: A source with `srcN_has`=0 (an immediate) sets no constraint and reads no table entry. It is reported with vreg 0, live-in 0 and arch 0.
- R7: A word holds at most 6 ops. The op goes to the lowest word at or after its target that has fewer than 6 ops.
- R8: `res_dep_valid`/`res_dep_word` give the latest producer word over all non-live-in register sources of every op placed in the chosen word so far, this op included. It is always lower than `res_word`.
- R9: An op aborts when it has a destination and 32 temporaries are already allocated, when 256 ops are already placed, or when no word from its target up to word 63 has a free slot. The aborting op and all later ops give no result and change no state, and `abort` stays at 1 until the next `frame_start`.
- R10: An accepted op's result appears with `res_valid`=1 in the cycle after the edge that takes the op. Otherwise `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Begin a new region and clear all state |
| op_valid | input | 1 | A micro-op is presented this cycle |
| src0_has | input | 1 | Source 0 is a register |
| src0_phys | input | 5 | Source 0 physical register |
| src0_arch | input | 4 | Source 0 architectural register |
| src1_has | input | 1 | Source 1 is a register |
| src1_phys | input | 5 | Source 1 physical register |
| src1_arch | input | 4 | Source 1 architectural register |
| dst_has | input | 1 | Op writes a register |
| dst_phys | input | 5 | Destination physical register |
| dst_arch | input | 4 | Destination architectural register |
| dispatch_cyc | input | 12 | Cycle the op was dispatched |
| retire_cyc | input | 12 | Cycle the op retired |
| res_valid | output | 1 | Result record valid |
| res_word | output | 6 | Chosen word index |
| res_src0_vreg | output | 5 | Source 0 temporary register |
| res_src0_livein | output | 1 | Source 0 is a live-in |
| res_src0_arch | output | 4 | Source 0 live-in architectural register |
| res_src1_vreg | output | 5 | Source 1 temporary register |
| res_src1_livein | output | 1 | Source 1 is a live-in |
| res_src1_arch | output | 4 | Source 1 live-in architectural register |
| res_dst_vreg | output | 5 | Allocated destination temporary register |
| res_dep_valid | output | 1 | Chosen word has a dependency prefix |
| res_dep_word | output | 6 | Dependency prefix of the chosen word |
| abort | output | 1 | Region construction cancelled (sticky) |

## Verification
The hardest conditions to reach are the three abort causes. Each needs a long, specific history inside one region. To exhaust the pool, the bench issues 32 destination-writing ops with no sources. To reach the op budget, it issues 256 register-free ops, which fill words 0 to 42. To run out of word space, it builds a chain of maximum-latency producers that drives the target beyond word 63. For full-word overflow and dependency prefixes, the bench fills words with unconstrained ops before it issues a dependent op. It also sweeps every latency, including the clamped ones, and every pair of two-source latencies from 1 to 4.

// File: rtl/twp_pkg.sv
// Shared constants and types of the word placement unit.
// Assumes LAT_W <= WORD_W so a word plus a latency fits in WORD_W+1 bits.
package twp_pkg;
    localparam int PHYS_REGS = 32;
    localparam int ARCH_REGS = 16;
    localparam int TEMP_REGS = 32;
    localparam int MAX_OPS   = 256;
    localparam int SLOTS     = 6;
    localparam int MAX_WORDS = 64;
    localparam int LAT_W     = 4;
    localparam int CYC_W     = 12;
    localparam int NSRC      = 2;

    localparam int PHYS_W  = $clog2(PHYS_REGS);
    localparam int ARCH_W  = $clog2(ARCH_REGS);
    localparam int VREG_W  = $clog2(TEMP_REGS);
    localparam int WORD_W  = $clog2(MAX_WORDS);
    localparam int SLOT_W  = $clog2(SLOTS + 1);
    localparam int OPS_W   = $clog2(MAX_OPS + 1);
    localparam int LAT_MAX = (1 << LAT_W) - 1;

    typedef struct packed {
        logic              valid;
        logic              livein;
        logic [VREG_W-1:0] vreg;
        logic [WORD_W-1:0] word;
        logic [ARCH_W-1:0] arch;
        logic [LAT_W-1:0]  lat;
    } map_entry_t;
endpackage

// File: rtl/twp_map_table.sv
// Physical-to-temporary mapping table, one entry per physical register.
// Two combinational read ports, up to two live-in creations and one
// destination write per cycle; the destination write wins on a clash.
// Assumes two live-in creations to the same index carry the same content.
module twp_map_table
    import twp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [NSRC-1:0][PHYS_W-1:0] rd_idx,
    output map_entry_t [NSRC-1:0]      rd_ent,
    input  logic [NSRC-1:0]            lw_en,
    input  logic [NSRC-1:0][PHYS_W-1:0] lw_idx,
    input  logic [NSRC-1:0][ARCH_W-1:0] lw_arch,
    input  logic                       dw_en,
    input  logic [PHYS_W-1:0]          dw_idx,
    input  map_entry_t                 dw_ent
);
    map_entry_t tbl [PHYS_REGS];

    // Read ports: plain indexed lookup.
    always_comb begin
        for (int s = 0; s < NSRC; s++) rd_ent[s] = tbl[rd_idx[s]];
    end

    for (genvar g = 0; g < PHYS_REGS; g++) begin : g_ent
        map_entry_t li_ent;

        // Live-in entry content for this index (last matching port wins).
        always_comb begin
            li_ent = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (lw_en[s] && lw_idx[s] == PHYS_W'(g)) begin
                    li_ent        = '0;
                    li_ent.valid  = 1'b1;
                    li_ent.livein = 1'b1;
                    li_ent.arch   = lw_arch[s];
                end
            end
        end

        // Entry update: clear, destination write, then live-in creation.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                        tbl[g] <= '0;
            else if (dw_en && dw_idx == PHYS_W'(g))     tbl[g] <= dw_ent;
            else if (li_ent.valid)                      tbl[g] <= li_ent;
        end
    end
endmodule

// File: rtl/twp_ready_calc.sv
// Computes an op's target word (max of producer word + latency) and the
// latest producer word it depends on, from the looked-up source entries.
// Live-ins and immediates contribute nothing.
module twp_ready_calc
    import twp_pkg::*;
(
    input  logic [NSRC-1:0]       src_has,
    input  map_entry_t [NSRC-1:0] ent,
    output logic [WORD_W:0]       target,
    output logic                  dep_v,
    output logic [WORD_W-1:0]     dep_word
);
    // Fold all register sources into a ready word and a dependency word.
    always_comb begin
        logic [WORD_W:0] t;
        t        = '0;
        target   = '0;
        dep_v    = 1'b0;
        dep_word = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_has[s] && ent[s].valid && !ent[s].livein) begin
                t = {1'b0, ent[s].word} + (WORD_W+1)'(ent[s].lat);
                if (t > target) target = t;
                if (!dep_v || ent[s].word > dep_word) dep_word = ent[s].word;
                dep_v = 1'b1;
            end
        end
    end
endmodule

// File: rtl/twp_word_slots.sv
// Per-word occupancy counts and dependency prefixes. Finds the lowest word
// at or after a target that still has a free slot, and records a placement.
// A target at or beyond MAX_WORDS yields found = 0.
module twp_word_slots
    import twp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [WORD_W:0]   target,
    output logic              found,
    output logic [WORD_W-1:0] pick,
    output logic              pick_dep_v,
    output logic [WORD_W-1:0] pick_dep,
    input  logic              put_en,
    input  logic [WORD_W-1:0] put_word,
    input  logic              put_dep_v,
    input  logic [WORD_W-1:0] put_dep
);
    logic [SLOT_W-1:0] cnt   [MAX_WORDS];
    logic              dep_v [MAX_WORDS];
    logic [WORD_W-1:0] dep_w [MAX_WORDS];

    // Forward search for the first word with room.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (!found && (WORD_W+1)'(i) >= target && cnt[i] < SLOT_W'(SLOTS)) begin
                found = 1'b1;
                pick  = WORD_W'(i);
            end
        end
        pick_dep_v = dep_v[pick];
        pick_dep   = dep_w[pick];
    end

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        // Word state update on clear or on a placement into this word.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                cnt[g]   <= '0;
                dep_v[g] <= 1'b0;
                dep_w[g] <= '0;
            end else if (put_en && put_word == WORD_W'(g)) begin
                cnt[g]   <= cnt[g] + SLOT_W'(1);
                dep_v[g] <= put_dep_v;
                dep_w[g] <= put_dep;
            end
        end
    end
endmodule

// File: rtl/trace_word_placer.sv
// Top of the word placement unit. Accepts one retired micro-op per cycle,
// resolves its sources, places it into a word, allocates its destination
// temporary and registers a result record one cycle later.
// Assumes ops arrive in retirement order and retire_cyc >= dispatch_cyc.
module trace_word_placer
    import twp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              op_valid,
    input  logic              src0_has,
    input  logic [PHYS_W-1:0] src0_phys,
    input  logic [ARCH_W-1:0] src0_arch,
    input  logic              src1_has,
    input  logic [PHYS_W-1:0] src1_phys,
    input  logic [ARCH_W-1:0] src1_arch,
    input  logic              dst_has,
    input  logic [PHYS_W-1:0] dst_phys,
    input  logic [ARCH_W-1:0] dst_arch,
    input  logic [CYC_W-1:0]  dispatch_cyc,
    input  logic [CYC_W-1:0]  retire_cyc,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word,
    output logic [VREG_W-1:0] res_src0_vreg,
    output logic              res_src0_livein,
    output logic [ARCH_W-1:0] res_src0_arch,
    output logic [VREG_W-1:0] res_src1_vreg,
    output logic              res_src1_livein,
    output logic [ARCH_W-1:0] res_src1_arch,
    output logic [VREG_W-1:0] res_dst_vreg,
    output logic              res_dep_valid,
    output logic [WORD_W-1:0] res_dep_word,
    output logic              abort
);
    logic [NSRC-1:0]             s_has;
    logic [NSRC-1:0][PHYS_W-1:0] s_phys;
    logic [NSRC-1:0][ARCH_W-1:0] s_arch;
    map_entry_t [NSRC-1:0]       s_ent;
    logic [NSRC-1:0]             s_new_li;
    logic [NSRC-1:0]             s_livein;
    logic [NSRC-1:0][VREG_W-1:0] s_vreg;
    logic [NSRC-1:0][ARCH_W-1:0] s_arch_o;

    logic [WORD_W:0]   target;
    logic              op_dep_v;
    logic [WORD_W-1:0] op_dep;
    logic              found;
    logic [WORD_W-1:0] pick;
    logic              pick_dep_v;
    logic [WORD_W-1:0] pick_dep;
    logic              new_dep_v;
    logic [WORD_W-1:0] new_dep;

    logic [VREG_W:0]   vreg_cnt;
    logic [OPS_W-1:0]  op_cnt;
    logic [CYC_W-1:0]  lat_diff;
    logic [LAT_W-1:0]  lat;
    logic              accept, bad, commit;
    map_entry_t        dst_ent;

    assign s_has  = {src1_has, src0_has};
    assign s_phys = {src1_phys, src0_phys};
    assign s_arch = {src1_arch, src0_arch};

    twp_map_table u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .rd_idx  (s_phys),
        .rd_ent  (s_ent),
        .lw_en   (s_new_li & {NSRC{commit}}),
        .lw_idx  (s_phys),
        .lw_arch (s_arch),
        .dw_en   (commit && dst_has),
        .dw_idx  (dst_phys),
        .dw_ent  (dst_ent)
    );

    twp_ready_calc u_ready (
        .src_has  (s_has),
        .ent      (s_ent),
        .target   (target),
        .dep_v    (op_dep_v),
        .dep_word (op_dep)
    );

    twp_word_slots u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (frame_start),
        .target     (target),
        .found      (found),
        .pick       (pick),
        .pick_dep_v (pick_dep_v),
        .pick_dep   (pick_dep),
        .put_en     (commit),
        .put_word   (pick),
        .put_dep_v  (new_dep_v),
        .put_dep    (new_dep)
    );

    // Per-source classification: new live-in, known live-in or produced value.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            s_new_li[s] = s_has[s] && !s_ent[s].valid;
            s_livein[s] = s_has[s] && (!s_ent[s].valid || s_ent[s].livein);
            s_vreg[s]   = (s_has[s] && s_ent[s].valid && !s_ent[s].livein) ? s_ent[s].vreg : '0;
            s_arch_o[s] = !s_livein[s] ? '0 : (s_ent[s].valid ? s_ent[s].arch : s_arch[s]);
        end
    end

    // Measured latency, held within 1..LAT_MAX.
    always_comb begin
        lat_diff = retire_cyc - dispatch_cyc;
        if (lat_diff == '0)                   lat = LAT_W'(1);
        else if (lat_diff > CYC_W'(LAT_MAX))  lat = LAT_W'(LAT_MAX);
        else                                  lat = lat_diff[LAT_W-1:0];
    end

    // Accept/abort decision and the merged dependency prefix of the word.
    always_comb begin
        accept    = op_valid && !frame_start && !abort;
        bad       = (dst_has && vreg_cnt == (VREG_W+1)'(TEMP_REGS))
                 || (op_cnt == OPS_W'(MAX_OPS)) || !found;
        commit    = accept && !bad;
        new_dep_v = pick_dep_v || op_dep_v;
        if (pick_dep_v && op_dep_v) new_dep = (pick_dep > op_dep) ? pick_dep : op_dep;
        else if (op_dep_v)          new_dep = op_dep;
        else                        new_dep = pick_dep;
        dst_ent        = '0;
        dst_ent.valid  = 1'b1;
        dst_ent.vreg   = vreg_cnt[VREG_W-1:0];
        dst_ent.word   = pick;
        dst_ent.arch   = dst_arch;
        dst_ent.lat    = lat;
    end

    // Region counters and the sticky abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            vreg_cnt <= '0;
            op_cnt   <= '0;
            abort    <= 1'b0;
        end else begin
            if (accept && bad) abort <= 1'b1;
            if (commit) begin
                op_cnt <= op_cnt + OPS_W'(1);
                if (dst_has) vreg_cnt <= vreg_cnt + (VREG_W+1)'(1);
            end
        end
    end

    // Result record register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid       <= 1'b0;
            res_word        <= '0;
            res_src0_vreg   <= '0;
            res_src0_livein <= 1'b0;
            res_src0_arch   <= '0;
            res_src1_vreg   <= '0;
            res_src1_livein <= 1'b0;
            res_src1_arch   <= '0;
            res_dst_vreg    <= '0;
            res_dep_valid   <= 1'b0;
            res_dep_word    <= '0;
        end else begin
            res_valid <= commit;
            if (commit) begin
                res_word        <= pick;
                res_src0_vreg   <= s_vreg[0];
                res_src0_livein <= s_livein[0];
                res_src0_arch   <= s_arch_o[0];
                res_src1_vreg   <= s_vreg[1];
                res_src1_livein <= s_livein[1];
                res_src1_arch   <= s_arch_o[1];
                res_dst_vreg    <= dst_has ? vreg_cnt[VREG_W-1:0] : '0;
                res_dep_valid   <= new_dep_v;
                res_dep_word    <= new_dep;
            end
        end
    end
endmodule

// File: rtl/trace_word_placer_chk.sv
// Property checker for the word placement unit, bound to the top module.
module trace_word_placer_chk
    import twp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              op_valid,
    input logic              src0_has,
    input logic              res_valid,
    input logic [WORD_W-1:0] res_word,
    input logic [VREG_W-1:0] res_src0_vreg,
    input logic              res_src0_livein,
    input logic [ARCH_W-1:0] res_src0_arch,
    input logic              res_dep_valid,
    input logic [WORD_W-1:0] res_dep_word,
    input logic              abort
);
    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!abort && !res_valid)); // R1

    AST_IMM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !frame_start && !src0_has) |=>
        (!res_valid || (!res_src0_livein && res_src0_vreg == '0 && res_src0_arch == '0))); // R6

    AST_DEP_BEFORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dep_valid) |-> (res_dep_word < res_word)); // R8

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !frame_start) |=> abort); // R9

    AST_NO_RESULT_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !frame_start) |=> !res_valid); // R9

    AST_RESULT_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid && !frame_start)); // R10
endmodule

bind trace_word_placer trace_word_placer_chk u_chk (.*);

// File: tb/trace_word_placer_bench.sv
`timescale 1ns/1ps
module trace_word_placer_bench;
    import twp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, op_valid = 1'b0;
    logic src0_has = 0, src1_has = 0, dst_has = 0;
    logic [PHYS_W-1:0] src0_phys = '0, src1_phys = '0, dst_phys = '0;
    logic [ARCH_W-1:0] src0_arch = '0, src1_arch = '0, dst_arch = '0;
    logic [CYC_W-1:0]  dispatch_cyc = '0, retire_cyc = '0;
    logic res_valid, res_src0_livein, res_src1_livein, res_dep_valid, abort;
    logic [WORD_W-1:0] res_word, res_dep_word;
    logic [VREG_W-1:0] res_src0_vreg, res_src1_vreg, res_dst_vreg;
    logic [ARCH_W-1:0] res_src0_arch, res_src1_arch;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench-side model state, built from the requirements.
    bit m_valid [PHYS_REGS];
    bit m_li    [PHYS_REGS];
    int m_vreg  [PHYS_REGS];
    int m_word  [PHYS_REGS];
    int m_arch  [PHYS_REGS];
    int m_lat   [PHYS_REGS];
    int w_cnt   [MAX_WORDS];
    bit w_dv    [MAX_WORDS];
    int w_dep   [MAX_WORDS];
    int m_nv, m_nops;
    bit m_abort;

    always #4 clk = ~clk;

    trace_word_placer u_trace_word_placer (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < PHYS_REGS; i++) begin
            m_valid[i] = 0; m_li[i] = 0; m_vreg[i] = 0; m_word[i] = 0; m_arch[i] = 0; m_lat[i] = 0;
        end
        for (int i = 0; i < MAX_WORDS; i++) begin
            w_cnt[i] = 0; w_dv[i] = 0; w_dep[i] = 0;
        end
        m_nv = 0; m_nops = 0; m_abort = 0;
    endtask

    // R1: start a region and check the cleared outputs.
    task automatic new_frame();
        frame_start = 1'b1;
        op_valid    = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        model_clear();
        chk("R1", "abort after frame_start", int'(abort), 0);
        chk("R1", "res_valid after frame_start", int'(res_valid), 0);
    endtask

    // Present one op, predict its record, check it one cycle later.
    task automatic do_op(string req, bit h0, int p0, int a0, bit h1, int p1, int a1,
                         bit dh, int dp, int da, int disp, int ret);
        bit li [2]; int vr [2]; int ar [2];
        int hs [2]; int ps [2]; int as_ [2];
        int target, dep, lat, pick;
        bit depv, found, bad, commit;
        hs[0] = h0; hs[1] = h1; ps[0] = p0; ps[1] = p1; as_[0] = a0; as_[1] = a1;
        target = 0; depv = 0; dep = 0;
        for (int s = 0; s < 2; s++) begin
            li[s] = 0; vr[s] = 0; ar[s] = 0;
            if (hs[s] != 0) begin
                if (!m_valid[ps[s]]) begin li[s] = 1; ar[s] = as_[s]; end
                else if (m_li[ps[s]]) begin li[s] = 1; ar[s] = m_arch[ps[s]]; end
                else begin
                    vr[s] = m_vreg[ps[s]];
                    if (m_word[ps[s]] + m_lat[ps[s]] > target) target = m_word[ps[s]] + m_lat[ps[s]];
                    if (!depv || m_word[ps[s]] > dep) dep = m_word[ps[s]];
                    depv = 1;
                end
            end
        end
        lat = ret - disp;
        if (lat < 1) lat = 1;
        if (lat > LAT_MAX) lat = LAT_MAX;
        found = 0; pick = 0;
        for (int w = target; w < MAX_WORDS; w++)
            if (!found && w_cnt[w] < SLOTS) begin found = 1; pick = w; end
        bad    = (dh && m_nv == TEMP_REGS) || (m_nops == MAX_OPS) || !found;
        commit = !m_abort && !bad;

        src0_has = h0; src0_phys = PHYS_W'(p0); src0_arch = ARCH_W'(a0);
        src1_has = h1; src1_phys = PHYS_W'(p1); src1_arch = ARCH_W'(a1);
        dst_has = dh; dst_phys = PHYS_W'(dp); dst_arch = ARCH_W'(da);
        dispatch_cyc = CYC_W'(disp); retire_cyc = CYC_W'(ret);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;

        chk(req, "res_valid (R10)", int'(res_valid), int'(commit));
        chk(req, "abort", int'(abort), int'(m_abort || bad));
        if (commit) begin
            if (w_dv[pick]) begin
                if (!depv || w_dep[pick] > dep) dep = w_dep[pick];
                depv = 1;
            end
            chk(req, "res_word", int'(res_word), pick);
            chk(req, "src0 livein", int'(res_src0_livein), int'(li[0]));
            chk(req, "src0 vreg", int'(res_src0_vreg), vr[0]);
            chk(req, "src0 arch", int'(res_src0_arch), ar[0]);
            chk(req, "src1 livein", int'(res_src1_livein), int'(li[1]));
            chk(req, "src1 vreg", int'(res_src1_vreg), vr[1]);
            chk(req, "src1 arch", int'(res_src1_arch), ar[1]);
            chk(req, "dst vreg", int'(res_dst_vreg), dh ? m_nv : 0);
            chk(req, "dep valid (R8)", int'(res_dep_valid), int'(depv));
            if (depv) chk(req, "dep word (R8)", int'(res_dep_word), dep);
            for (int s = 0; s < 2; s++)
                if (hs[s] != 0 && !m_valid[ps[s]]) begin
                    m_valid[ps[s]] = 1; m_li[ps[s]] = 1; m_arch[ps[s]] = as_[s];
                    m_vreg[ps[s]] = 0; m_word[ps[s]] = 0; m_lat[ps[s]] = 0;
                end
            if (dh) begin
                m_valid[dp] = 1; m_li[dp] = 0; m_vreg[dp] = m_nv; m_word[dp] = pick;
                m_arch[dp] = da; m_lat[dp] = lat; m_nv++;
            end
            w_cnt[pick]++; w_dv[pick] = depv; w_dep[pick] = dep;
            m_nops++;
        end else if (!m_abort) begin
            m_abort = 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "abort after reset", int'(abort), 0);
        chk("R1", "res_valid after reset", int'(res_valid), 0);

        // R4, R5: latency sweep including zero and values above the cap.
        for (int l = 0; l <= 20; l++) begin
            new_frame();
            do_op("R4", 0, 0, 0, 0, 0, 0, 1, 1, 2, 100, 100 + l);
            do_op("R5", 1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        end

        // R5, R8: two-source latency pairs.
        for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
                new_frame();
                do_op("R5", 0, 0, 0, 0, 0, 0, 1, 2, 1, 10, 10 + a);
                do_op("R5", 0, 0, 0, 0, 0, 0, 1, 3, 2, 10, 10 + b);
                do_op("R8", 1, 2, 1, 1, 3, 2, 1, 4, 3, 20, 21);
                do_op("R8", 1, 4, 3, 1, 2, 1, 0, 0, 0, 0, 0);
            end
        end

        // R2, R3: live-ins, their reuse, then a produced value.
        new_frame();
        do_op("R2", 1, 5, 3, 1, 5, 3, 0, 0, 0, 0, 0);
        do_op("R2", 1, 5, 7, 0, 0, 0, 1, 6, 4, 5, 7);
        do_op("R3", 0, 0, 0, 0, 0, 0, 1, 5, 3, 5, 6);
        do_op("R3", 1, 5, 3, 1, 6, 4, 1, 9, 1, 8, 9);
        // R1: an op together with frame_start is dropped; p5 is a live-in again.
        src0_has = 1; src0_phys = 5; op_valid = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; frame_start = 1'b0; model_clear();
        chk("R1", "op with frame_start dropped", int'(res_valid), 0);
        do_op("R1", 1, 5, 3, 0, 0, 0, 0, 0, 0, 0, 0);

        // R7: fill words, then overflow into the next word with room.
        new_frame();
        for (int i = 0; i < 14; i++) do_op("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R7", 0, 0, 0, 0, 0, 0, 1, 6, 1, 0, 1);
        for (int i = 0; i < 5; i++) do_op("R7", 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R7", 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0);

        // R6: immediate whose register field names a late producer.
        new_frame();
        do_op("R6", 0, 0, 0, 0, 0, 0, 1, 7, 1, 0, 15);
        do_op("R6", 0, 7, 1, 0, 7, 1, 0, 0, 0, 0, 0);

        // R9: temporary pool exhaustion.
        new_frame();
        for (int i = 0; i < TEMP_REGS; i++) do_op("R3", 0, 0, 0, 0, 0, 0, 1, i, 0, 0, 1);
        do_op("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        do_op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        new_frame();
        do_op("R1", 1, 3, 2, 0, 0, 0, 1, 4, 2, 0, 1);

        // R9: op budget.
        new_frame();
        for (int i = 0; i < MAX_OPS; i++) do_op("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R9: word space exhausted by a chain of slow producers.
        new_frame();
        do_op("R9", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 15);
        for (int i = 1; i < 5; i++) do_op("R9", 1, i, 0, 0, 0, 0, 1, i + 1, 0, 0, 15);
        do_op("R9", 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule